// File: doc/BRIEF.md
# Single-Precision Predicated Compare Unit

This unit compares two IEEE-754 single-precision values: the lowest 32-bit lane of a wide first operand and a 32-bit second operand. A 5-bit predicate taken from an 8-bit immediate selects the test. Every comparison falls into exactly one of four relations: less, equal, greater or unordered. Each predicate maps these four relations to a truth value and also decides whether a quiet NaN counts as an invalid operation. Besides the boolean result, the unit reports an invalid-operation flag and a denormal-operand flag.

The boolean result is then placed in one of three destination styles, selected by a 2-bit mode input. Merge mode keeps the upper bits of the first operand. Three-operand mode copies bits 127:32 of the first operand and clears everything above bit 127. Mask mode writes a single bit into a mask word, gated by a write-mask bit. The formatted destination, the mask and both flags are registered together and appear one cycle after an input strobe, with a matching output strobe.

Top module: `sp_cmp_unit`

## Requirements
- R1: Relation classification: if either operand is NaN the relation is unordered. Otherwise +0 and -0 are equal, and all other values, including infinities, are ordered by sign and magnitude.
- R2: Predicate p in 0..15 gives a truth mask over (less, equal, greater, unordered), listed here for p = 0 to 15 in that order: 0100, 1000, 1100, 0001, 1011, 0111, 0011, 1110, 0101, 1001, 1101, 0000, 1010, 0110, 0010, 1111.
- R3: Predicate p in 16..31 gives the same truth result as predicate p-16.
- R4: A quiet NaN on either operand raises invalid only under a signaling predicate. The signaling predicates are 1, 2, 5, 6, 9, 10, 13 and 14, and 16, 19, 20, 23, 24, 27, 28 and 31.
- R5: A signaling NaN on either operand always raises invalid, whatever the predicate. A signaling NaN has an all-ones exponent, a clear top fraction bit and a nonzero fraction.
- R6: The denormal flag is raised when either operand is subnormal, meaning a zero exponent and a nonzero fraction.
- R7: Mode encoding is 0 = merge, 1 = three-operand, 2 = mask, and 3 behaves as three-operand. In merge mode only imm bits 2:0 form the predicate, with bits 4:3 taken as zero. In the other modes imm bits 4:0 form the predicate. Imm bits 7:5 are always ignored.
- R8: In merge and three-operand modes, dest bits 31:0 are all ones for true and all zeros for false.
- R9: In merge mode, dest bits above 31 equal the first operand's bits above 31.
- R10: In three-operand mode, dest bits 127:32 equal the first operand's bits 127:32, and dest bits above 127 are zero.
- R11: In mask mode, mask bit 0 is the result ANDed with write-mask bit 0. All other mask bits are zero, and dest is zero. In the other modes the mask output is zero.
- R12: Outputs are captured at the clock edge where the input strobe is high, and the output strobe is high for exactly the following cycle. Without a strobe, the registered outputs hold their values.
- R13: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| mode_i | input | 2 | Destination style |
| imm_i | input | 8 | Predicate immediate |
| src_a_i | input | VEC_W | First operand; lane 0 is compared, upper bits feed merge |
| src_b_i | input | 32 | Second operand |
| wmask_i | input | MASK_W | Write mask; only bit 0 is used |
| valid_o | output | 1 | Output strobe |
| dest_o | output | VEC_W | Formatted vector destination |
| mask_o | output | MASK_W | Mask destination |
| invalid_o | output | 1 | Invalid-operation flag |
| denorm_o | output | 1 | Denormal-operand flag |

## Verification
The bench runs all 32 predicates against a less, an equal, a greater and a quiet-NaN pair. A wrong truth mask or a wrong signaling bit therefore shows up as a wrong lane result or a wrong invalid flag on one specific predicate. Signed zeros, infinities and negative pairs are aimed at comparators that use raw unsigned ordering, which would put -1 above 1 or report +0 and -0 as unequal. Further cases feed imm values whose bits 7:3 are set, in both merge and three-operand mode, to catch a decoder that reads the wrong predicate bits. The remaining cases check the merged, copied and zeroed upper lanes, mask bit 0 with the write mask both clear and set, and that the outputs hold when no strobe is given.

// File: rtl/sp_cmp_pkg.sv
package sp_cmp_pkg;
  localparam int LANE_W = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int XMM_W  = 128;

  typedef enum logic [1:0] {
    MODE_MERGE = 2'd0,
    MODE_THREE = 2'd1,
    MODE_MASK  = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef struct packed {
    logic                sign;
    logic [LANE_W-2:0]   mag;
    logic                nan;
    logic                snan;
    logic                zero;
    logic                sub;
  } fp_class_t;

  // bit order {lt, eq, gt, un}
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;
endpackage

// File: rtl/sp_classify.sv
module sp_classify
  import sp_cmp_pkg::*;
(
  input  logic [LANE_W-1:0] val_i,
  output fp_class_t         cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max, exp_min, man_nz;

  assign exp_f   = val_i[LANE_W-2 -: EXP_W];
  assign man_f   = val_i[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls_o.sign = val_i[LANE_W-1];
    cls_o.mag  = val_i[LANE_W-2:0];
    cls_o.nan  = exp_max & man_nz;
    cls_o.snan = exp_max & man_nz & ~man_f[MAN_W-1];
    cls_o.zero = exp_min & ~man_nz;
    cls_o.sub  = exp_min & man_nz;
  end
endmodule

// File: rtl/sp_relation.sv
module sp_relation
  import sp_cmp_pkg::*;
(
  input  fp_class_t cls_a_i,
  input  fp_class_t cls_b_i,
  output rel_t      rel_o
);
  logic mag_lt, mag_eq, same_sign, both_zero;
  logic unused_cls;

  assign mag_lt    = cls_a_i.mag < cls_b_i.mag;
  assign mag_eq    = cls_a_i.mag == cls_b_i.mag;
  assign same_sign = cls_a_i.sign == cls_b_i.sign;
  assign both_zero = cls_a_i.zero & cls_b_i.zero;
  assign unused_cls = cls_a_i.snan ^ cls_b_i.snan ^ cls_a_i.sub ^ cls_b_i.sub;

  always_comb begin
    rel_o = '0;
    if (cls_a_i.nan || cls_b_i.nan) begin
      rel_o.un = 1'b1;
    end else if (both_zero || (same_sign && mag_eq)) begin
      rel_o.eq = 1'b1;
    end else if (!same_sign) begin
      rel_o.lt = cls_a_i.sign;
      rel_o.gt = ~cls_a_i.sign;
    end else begin
      // same sign, different magnitude: negative flips the order
      rel_o.lt = cls_a_i.sign ? ~mag_lt : mag_lt;
      rel_o.gt = ~rel_o.lt;
    end
  end
endmodule

// File: rtl/sp_pred_decode.sv
module sp_pred_decode
  import sp_cmp_pkg::*;
(
  input  mode_e      mode_i,
  input  logic [7:0] imm_i,
  output logic [3:0] truth_o,
  output logic       signaling_o
);
  logic [4:0] pred;
  logic       unused_imm;

  assign unused_imm = ^imm_i[7:5];
  assign pred = (mode_i == MODE_MERGE) ? {2'b00, imm_i[2:0]} : imm_i[4:0];

  always_comb begin
    unique case (pred[3:0])
      4'h0: truth_o = 4'b0100;
      4'h1: truth_o = 4'b1000;
      4'h2: truth_o = 4'b1100;
      4'h3: truth_o = 4'b0001;
      4'h4: truth_o = 4'b1011;
      4'h5: truth_o = 4'b0111;
      4'h6: truth_o = 4'b0011;
      4'h7: truth_o = 4'b1110;
      4'h8: truth_o = 4'b0101;
      4'h9: truth_o = 4'b1001;
      4'hA: truth_o = 4'b1101;
      4'hB: truth_o = 4'b0000;
      4'hC: truth_o = 4'b1010;
      4'hD: truth_o = 4'b0110;
      4'hE: truth_o = 4'b0010;
      default: truth_o = 4'b1111;
    endcase
  end

  // lower half signals where bit0 != bit1; upper half inverts that
  assign signaling_o = pred[0] ^ pred[1] ^ pred[4];
endmodule

// File: rtl/sp_dest_format.sv
module sp_dest_format
  import sp_cmp_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 8
) (
  input  mode_e              mode_i,
  input  logic               res_i,
  input  logic [VEC_W-1:0]   src_a_i,
  input  logic [MASK_W-1:0]  wmask_i,
  output logic [VEC_W-1:0]   dest_o,
  output logic [MASK_W-1:0]  mask_o
);
  logic [LANE_W-1:0] lane;
  logic              unused_wm;

  assign lane = {LANE_W{res_i}};

  generate
    if (MASK_W > 1) begin : g_wm_hi
      assign unused_wm = ^wmask_i[MASK_W-1:1];
    end else begin : g_wm_one
      assign unused_wm = 1'b0;
    end
  endgenerate

  always_comb begin
    dest_o = '0;
    mask_o = '0;
    unique case (mode_i)
      MODE_MERGE: dest_o = {src_a_i[VEC_W-1:LANE_W], lane};
      MODE_MASK:  mask_o[0] = res_i & wmask_i[0];
      default:    dest_o[XMM_W-1:0] = {src_a_i[XMM_W-1:LANE_W], lane};
    endcase
  end
endmodule

// File: rtl/sp_cmp_unit.sv
module sp_cmp_unit
  import sp_cmp_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic [7:0]         imm_i,
  input  logic [VEC_W-1:0]   src_a_i,
  input  logic [LANE_W-1:0]  src_b_i,
  input  logic [MASK_W-1:0]  wmask_i,
  output logic               valid_o,
  output logic [VEC_W-1:0]   dest_o,
  output logic [MASK_W-1:0]  mask_o,
  output logic               invalid_o,
  output logic               denorm_o
);
  localparam int N_OPS = 2;

  mode_e             mode;
  logic [LANE_W-1:0] op [N_OPS];
  fp_class_t         cls [N_OPS];
  rel_t              rel;
  logic [3:0]        truth;
  logic              signaling, res, inv_d, den_d;
  logic [VEC_W-1:0]  dest_d;
  logic [MASK_W-1:0] mask_d;

  assign mode  = mode_e'(mode_i);
  assign op[0] = src_a_i[LANE_W-1:0];
  assign op[1] = src_b_i;

  generate
    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      sp_classify u_cls (.val_i(op[i]), .cls_o(cls[i]));
    end
  endgenerate

  sp_relation u_rel (.cls_a_i(cls[0]), .cls_b_i(cls[1]), .rel_o(rel));

  sp_pred_decode u_dec (
    .mode_i(mode), .imm_i(imm_i), .truth_o(truth), .signaling_o(signaling)
  );

  assign res   = |(truth & {rel.lt, rel.eq, rel.gt, rel.un});
  assign inv_d = cls[0].snan | cls[1].snan | (signaling & (cls[0].nan | cls[1].nan));
  assign den_d = cls[0].sub | cls[1].sub;

  sp_dest_format #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_fmt (
    .mode_i(mode), .res_i(res), .src_a_i(src_a_i), .wmask_i(wmask_i),
    .dest_o(dest_d), .mask_o(mask_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_o    <= '0;
      mask_o    <= '0;
      invalid_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else if (valid_i) begin
      dest_o    <= dest_d;
      mask_o    <= mask_d;
      invalid_o <= inv_d;
      denorm_o  <= den_d;
    end
  end
endmodule

// File: rtl/sp_cmp_unit_chk.sv
module sp_cmp_unit_chk #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [7:0]        imm_i,
  input logic [VEC_W-1:0]  src_a_i,
  input logic [31:0]       src_b_i,
  input logic [MASK_W-1:0] wmask_i,
  input logic              valid_o,
  input logic [VEC_W-1:0]  dest_o,
  input logic [MASK_W-1:0] mask_o,
  input logic              invalid_o,
  input logic              denorm_o
);
  logic snan_in, sub_in, unused_chk;

  assign snan_in = (&src_a_i[30:23] && !src_a_i[22] && |src_a_i[21:0]) ||
                   (&src_b_i[30:23] && !src_b_i[22] && |src_b_i[21:0]);
  assign sub_in  = (~|src_a_i[30:23] && |src_a_i[22:0]) ||
                   (~|src_b_i[30:23] && |src_b_i[22:0]);
  assign unused_chk = ^imm_i ^ ^wmask_i;

  p_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(dest_o) && $stable(mask_o)));
  p_snan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && snan_in) |=> invalid_o);
  p_denorm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_in) |=> denorm_o);
  p_lane_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dest_o[31:0] == '0 || dest_o[31:0] == '1));
  p_merge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0) |=> dest_o[VEC_W-1:32] == $past(src_a_i[VEC_W-1:32]));
  p_three_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[0]) |=>
      (dest_o[127:32] == $past(src_a_i[127:32]) && dest_o[VEC_W-1:128] == '0));
  p_mask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2) |=>
      (dest_o == '0 && $countones(mask_o) <= 1 && (mask_o[0] || mask_o == '0)));
  p_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2 && !wmask_i[0]) |=> mask_o == '0);
  p_nomask_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 2'd2) |=> mask_o == '0);
endmodule

bind sp_cmp_unit sp_cmp_unit_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .imm_i(imm_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .wmask_i(wmask_i),
  .valid_o(valid_o), .dest_o(dest_o), .mask_o(mask_o),
  .invalid_o(invalid_o), .denorm_o(denorm_o)
);

// File: tb/tb_sp_cmp_unit.sv
module tb_sp_cmp_unit;
  localparam int VEC_W  = 512;
  localparam int MASK_W = 8;

  localparam logic [31:0] F_ONE = 32'h3F80_0000, F_TWO = 32'h4000_0000;
  localparam logic [31:0] F_MONE = 32'hBF80_0000, F_MTWO = 32'hC000_0000;
  localparam logic [31:0] F_PZ = 32'h0, F_NZ = 32'h8000_0000;
  localparam logic [31:0] F_PINF = 32'h7F80_0000, F_NINF = 32'hFF80_0000;
  localparam logic [31:0] F_MAX = 32'h7F7F_FFFF, F_QNAN = 32'h7FC0_0000;
  localparam logic [31:0] F_SNAN = 32'h7F80_0001, F_SUB = 32'h0000_0001;
  localparam logic [3:0] TM [16] = '{4'b0100, 4'b1000, 4'b1100, 4'b0001,
                                     4'b1011, 4'b0111, 4'b0011, 4'b1110,
                                     4'b0101, 4'b1001, 4'b1101, 4'b0000,
                                     4'b1010, 4'b0110, 4'b0010, 4'b1111};

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [7:0] imm_i = '0;
  logic [VEC_W-1:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [MASK_W-1:0] wmask_i = '0;
  logic valid_o, invalid_o, denorm_o;
  logic [VEC_W-1:0] dest_o;
  logic [MASK_W-1:0] mask_o;
  logic [VEC_W-1:0] pat;
  int n_tests = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  sp_cmp_unit #(.VEC_W(VEC_W), .MASK_W(MASK_W)) dut (.*);

  task automatic check(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // rel: 0 lt, 1 eq, 2 gt, 3 unordered
  function automatic logic ref_truth(int p, int rel);
    logic [3:0] m = TM[p % 16];
    return m[3 - rel];
  endfunction

  function automatic logic ref_sig(int p);
    return (p % 16) inside {1, 2, 5, 6, 9, 10, 13, 14} ? (p < 16) : (p >= 16);
  endfunction

  task automatic run_case(string req, logic [1:0] md, logic [7:0] imm, logic [31:0] a,
                          logic [31:0] b, logic [MASK_W-1:0] wm, logic res,
                          logic inv, logic den);
    logic [VEC_W-1:0] ed = '0;
    logic [MASK_W-1:0] em = '0;
    @(negedge clk_i);
    mode_i = md; imm_i = imm; src_a_i = {pat[VEC_W-1:32], a}; src_b_i = b;
    wmask_i = wm; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (md == 2'd0) ed = {pat[VEC_W-1:32], {32{res}}};
    else if (md == 2'd2) em[0] = res & wm[0];
    else ed[127:0] = {pat[127:32], {32{res}}};
    check({req, " valid"}, VEC_W'(valid_o), VEC_W'(1));
    check({req, " dest"}, dest_o, ed);
    check({req, " mask"}, VEC_W'(mask_o), VEC_W'(em));
    check({req, " invalid"}, VEC_W'(invalid_o), VEC_W'(inv));
    check({req, " denorm"}, VEC_W'(denorm_o), VEC_W'(den));
  endtask

  task automatic t_reset();
    check("R13 valid", VEC_W'(valid_o), '0);
    check("R13 dest", dest_o, '0);
    check("R13 mask", VEC_W'(mask_o), '0);
    check("R13 flags", VEC_W'({invalid_o, denorm_o}), '0);
  endtask

  task automatic t_order();
    run_case("R1 1<2", 2'd1, 8'h01, F_ONE, F_TWO, '0, 1'b1, 1'b0, 1'b0);
    run_case("R1 -1<1", 2'd1, 8'h01, F_MONE, F_ONE, '0, 1'b1, 1'b0, 1'b0);
    run_case("R1 -2<-1", 2'd1, 8'h01, F_MTWO, F_MONE, '0, 1'b1, 1'b0, 1'b0);
    run_case("R1 -1<-2", 2'd1, 8'h01, F_MONE, F_MTWO, '0, 1'b0, 1'b0, 1'b0);
    run_case("R1 +0=-0", 2'd1, 8'h00, F_PZ, F_NZ, '0, 1'b1, 1'b0, 1'b0);
    run_case("R1 inf>max", 2'd1, 8'h0E, F_PINF, F_MAX, '0, 1'b1, 1'b0, 1'b0);
    run_case("R1 -inf<-1", 2'd1, 8'h01, F_NINF, F_MONE, '0, 1'b1, 1'b0, 1'b0);
  endtask

  // R2 R3 R4 across every predicate and relation
  task automatic t_all_preds();
    logic [31:0] av [4] = '{F_ONE, F_ONE, F_TWO, F_QNAN};
    logic [31:0] bv [4] = '{F_TWO, F_ONE, F_ONE, F_ONE};
    for (int p = 0; p < 32; p++) begin
      for (int r = 0; r < 4; r++) begin
        run_case(p < 16 ? "R2 pred" : "R3 R4 pred", 2'd1, 8'(p), av[r], bv[r], '0,
                 ref_truth(p, r), (r == 3) ? ref_sig(p) : 1'b0, 1'b0);
      end
    end
  endtask

  task automatic t_snan();
    run_case("R5 snan quiet pred", 2'd1, 8'h00, F_SNAN, F_ONE, '0, 1'b0, 1'b1, 1'b0);
    run_case("R5 snan b true pred", 2'd0, 8'h07, F_ONE, F_SNAN, '0, 1'b0, 1'b1, 1'b0);
    run_case("R4 qnan quiet pred", 2'd1, 8'h03, F_ONE, F_QNAN, '0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_denorm();
    run_case("R6 sub a", 2'd1, 8'h0E, F_SUB, F_PZ, '0, 1'b1, 1'b0, 1'b1);
    run_case("R6 sub b", 2'd1, 8'h01, F_PZ, F_SUB, '0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_imm_bits();
    // merge: 0xE9 -> pred 1 (LT_OS) on qnan: false, invalid
    run_case("R7 merge imm", 2'd0, 8'hE9, F_QNAN, F_ONE, '0, 1'b0, 1'b1, 1'b0);
    // three-op: 0x09 -> pred 9: true on unordered, invalid
    run_case("R7 three imm", 2'd1, 8'h09, F_QNAN, F_ONE, '0, 1'b1, 1'b1, 1'b0);
    run_case("R7 hi bits ignored", 2'd1, 8'hF3, F_QNAN, F_ONE, '0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_formats();
    run_case("R9 merge upper", 2'd0, 8'h00, F_ONE, F_ONE, '0, 1'b1, 1'b0, 1'b0);
    run_case("R8 R9 merge false", 2'd0, 8'h00, F_ONE, F_TWO, '0, 1'b0, 1'b0, 1'b0);
    run_case("R10 mode3", 2'd3, 8'h02, F_ONE, F_TWO, '0, 1'b1, 1'b0, 1'b0);
    run_case("R11 mask wm1", 2'd2, 8'h1E, F_TWO, F_ONE, 8'h01, 1'b1, 1'b0, 1'b0);
    run_case("R11 mask wm0", 2'd2, 8'h1E, F_TWO, F_ONE, 8'hFE, 1'b1, 1'b0, 1'b0);
    run_case("R11 mask all", 2'd2, 8'h0F, F_TWO, F_ONE, 8'hFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    logic [VEC_W-1:0] d0;
    run_case("R12 pulse", 2'd1, 8'h00, F_ONE, F_ONE, '0, 1'b1, 1'b0, 1'b0);
    d0 = dest_o;
    @(negedge clk_i);
    src_a_i = ~src_a_i; imm_i = 8'h0B; src_b_i = F_SNAN;
    @(negedge clk_i);
    check("R12 strobe low", VEC_W'(valid_o), '0);
    check("R12 dest hold", dest_o, d0);
    check("R12 flag hold", VEC_W'(invalid_o), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < VEC_W / 32; i++) pat[i*32 +: 32] = 32'hA5C3_0000 + 32'(i * 7);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_order();
    t_all_preds();
    t_snan();
    t_denorm();
    t_imm_bits();
    t_formats();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule